// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a bus-mastering network controller. Host software prepares a ring of descriptors in memory, each handing one receive buffer to the hardware. The block walks that ring through a word-wide memory port and takes frames from an incoming byte stream. For each frame it reads the current descriptor and, if the hardware owns it, writes the frame bytes into the buffer. It then writes a status word back that returns the descriptor to the host.

A ring-base input sets where the ring lives, and a run input starts and stops reception. When the current descriptor still belongs to the host, the frame is consumed and discarded, and a missed-frame counter advances. A process-state output tells the host what the engine is doing.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset `proc_state` is 0, `in_ready` is 0, `missed_cnt` is 0 and no memory request is issued.
- R2: A descriptor occupies four 32-bit words at byte offsets +0 (status), +4 (control), +8 (buffer address) and +12 (unused). The next sequential descriptor lies 16 bytes further on.
- R3: Frame byte i is stored at buffer address + i. Writes are 32-bit word writes with byte enables, where byte lane k (mem_be bit k, wdata bits 8k+7:8k) is address offset k within the word. Bytes of the buffer not covered by the frame are left untouched.
- R4: Control bits 10:0 give the buffer size in bytes. Frame bytes at index ≥ size are accepted but never written, and the written-back length still counts them.
- R5: On write-back the status word has bit 31 (ownership) cleared, bits 30:16 equal to the number of frame bytes received, bit 8 set (last descriptor of frame), and bit 15 set exactly when `in_err` accompanied the final byte.
- R6: When control bit 25 is set in the descriptor just used, the next descriptor read is at the ring base. Otherwise it is at current + 16.
- R7: If status bit 31 of the current descriptor is clear, the block waits. When a frame starts, it reads the descriptor again. If the descriptor is still not owned, the whole frame is consumed without any memory write and `missed_cnt` increments by one. A descriptor handed over before the next frame starts receives that frame.
- R8: With `run` low the block halts when it is between frames. It then holds `in_ready` low and issues no memory requests.
- R9: A ring-base write takes effect only while stopped. It forces the low five address bits to zero and restarts the ring at that base. A write while running is ignored.
- R10: `proc_state` is 0 when stopped, 1 while reading a descriptor, 2 while waiting for a frame, 3 while storing a frame or writing status, and 4 while discarding a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Receive enable |
| base_wr | input | 1 | Ring-base load strobe |
| base_in | input | AW | Ring-base value |
| in_valid | input | 1 | Byte stream valid |
| in_data | input | 8 | Byte stream data |
| in_last | input | 1 | Final byte of frame |
| in_err | input | 1 | Frame error, sampled with the final byte |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| missed_cnt | output | MISS_W | Frames dropped for lack of a descriptor |
| proc_state | output | 3 | Engine activity code |

## Verification
The hardest case to reach is the re-poll path. The ring has to wrap onto a descriptor whose ownership was already cleared by an earlier write-back, and a frame then has to arrive while the engine is parked on it. The stimulus fills the whole ring, wraps back to a consumed entry and sends a frame, which must be discarded and counted. It then hands that same entry back to the hardware before the next frame and expects the frame to land there. A base write issued during that parked state checks that the pointer is not disturbed while running.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int LEN_W    = 16;
    localparam int OWN_BIT  = 31;
    localparam int EOR_BIT  = 25;
    localparam int ERR_BIT  = 15;
    localparam int LAST_BIT = 8;

    typedef enum logic [3:0] {
        S_STOP, S_RD_STAT, S_WT_STAT, S_RD_CTL, S_WT_CTL, S_RD_BUF, S_WT_BUF,
        S_READY, S_NOTOWN, S_RECV, S_WB, S_DROP
    } rx_state_e;

    localparam logic [2:0] PS_STOP  = 3'd0;
    localparam logic [2:0] PS_FETCH = 3'd1;
    localparam logic [2:0] PS_WAIT  = 3'd2;
    localparam logic [2:0] PS_WRITE = 3'd3;
    localparam logic [2:0] PS_DROP  = 3'd4;
endpackage

// File: rtl/rxr_desc_ptr.sv
module rxr_desc_ptr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stopped,
    input  logic          base_wr,
    input  logic [AW-1:0] base_in,
    input  logic          advance,
    input  logic          wrap,
    output logic [AW-1:0] cur_addr
);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(31);
    localparam logic [AW-1:0] DESC_STEP  = AW'(16);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] cur;
    } ptr_t;

    ptr_t d, q;

    always_comb begin
        d = q;
        if (stopped && base_wr) begin
            d.base = base_in & ALIGN_MASK;
            d.cur  = base_in & ALIGN_MASK;
        end else if (advance) begin
            d.cur = wrap ? q.base : q.cur + DESC_STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cur_addr = q.cur;

    p_desc_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cur[3:0] == 4'd0) && (q.base[4:0] == 5'd0));

    p_base_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stopped) |-> (q.base == $past(q.base)));
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int AW     = 32,
    parameter int SIZE_W = 11,
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              base_wr,
    input  logic [AW-1:0]     base_in,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic              in_err,
    output logic              in_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic [MISS_W-1:0] missed_cnt,
    output logic [2:0]        proc_state
);
    localparam int PAD_W = LEN_W - SIZE_W;

    typedef struct packed {
        rx_state_e         st;
        logic              poll;
        logic [AW-1:0]     buf_addr;
        logic [SIZE_W-1:0] size;
        logic              eor;
        logic [LEN_W-1:0]  cnt;
        logic [31:0]       word;
        logic [3:0]        be;
        logic              err;
        logic [MISS_W-1:0] missed;
        logic              mreq;
        logic              mwe;
        logic              mstat;
        logic [AW-1:0]     maddr;
        logic [31:0]       mwdata;
        logic [3:0]        mbe;
    } eng_t;

    eng_t d, q;

    logic [AW-1:0]    cur_addr;
    logic             advance;
    logic             accept;
    logic [1:0]       lane;
    logic [LEN_W-1:0] size_ext;
    logic             in_buf;

    rxr_desc_ptr #(.AW(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .stopped  (q.st == S_STOP),
        .base_wr  (base_wr),
        .base_in  (base_in),
        .advance  (advance),
        .wrap     (q.eor),
        .cur_addr (cur_addr)
    );

    assign in_ready = (q.st == S_RECV) || (q.st == S_DROP);
    assign accept   = in_valid && in_ready;
    assign lane     = q.cnt[1:0];
    assign size_ext = {{PAD_W{1'b0}}, q.size};
    assign in_buf   = q.cnt < size_ext;

    always_comb begin
        d         = q;
        d.mreq    = 1'b0;
        d.mwe     = 1'b0;
        d.mstat   = 1'b0;
        d.mbe     = 4'h0;
        advance   = 1'b0;
        case (q.st)
            S_STOP:    if (run) d.st = S_RD_STAT;
            S_RD_STAT: begin
                d.mreq = 1'b1; d.maddr = cur_addr; d.st = S_WT_STAT;
            end
            S_WT_STAT: if (mem_rvalid) begin
                if (mem_rdata[OWN_BIT]) begin
                    d.poll = 1'b0; d.st = S_RD_CTL;
                end else if (q.poll) begin
                    d.poll = 1'b0; d.st = S_DROP;
                end else begin
                    d.st = S_NOTOWN;
                end
            end
            S_RD_CTL:  begin
                d.mreq = 1'b1; d.maddr = cur_addr + AW'(4); d.st = S_WT_CTL;
            end
            S_WT_CTL:  if (mem_rvalid) begin
                d.size = mem_rdata[SIZE_W-1:0];
                d.eor  = mem_rdata[EOR_BIT];
                d.st   = S_RD_BUF;
            end
            S_RD_BUF:  begin
                d.mreq = 1'b1; d.maddr = cur_addr + AW'(8); d.st = S_WT_BUF;
            end
            S_WT_BUF:  if (mem_rvalid) begin
                d.buf_addr = mem_rdata[AW-1:0];
                d.st       = S_READY;
            end
            S_READY:   begin
                d.cnt = '0; d.err = 1'b0; d.word = '0; d.be = '0;
                if (!run)          d.st = S_STOP;
                else if (in_valid) d.st = S_RECV;
            end
            S_NOTOWN:  begin
                if (!run) begin
                    d.st = S_STOP;
                end else if (in_valid) begin
                    d.poll = 1'b1; d.st = S_RD_STAT;
                end
            end
            S_RECV:    if (accept) begin
                if (in_buf) begin
                    d.word[{lane, 3'b000} +: 8] = in_data;
                    d.be[lane]                  = 1'b1;
                    if (lane == 2'd3 || in_last || q.cnt == size_ext - 1'b1) begin
                        d.mreq   = 1'b1;
                        d.mwe    = 1'b1;
                        d.maddr  = q.buf_addr + AW'({q.cnt[LEN_W-1:2], 2'b00});
                        d.mwdata = d.word;
                        d.mbe    = d.be;
                        d.word   = '0;
                        d.be     = '0;
                    end
                end
                d.cnt = q.cnt + 1'b1;
                if (in_last) begin
                    d.err = in_err;
                    d.st  = S_WB;
                end
            end
            S_WB:      begin
                d.mreq   = 1'b1;
                d.mwe    = 1'b1;
                d.mstat  = 1'b1;
                d.maddr  = cur_addr;
                d.mwdata = {1'b0, q.cnt[14:0], q.err, 6'b0, 1'b1, 8'h00};
                d.mbe    = 4'hF;
                advance  = 1'b1;
                d.st     = run ? S_RD_STAT : S_STOP;
            end
            S_DROP:    if (accept && in_last) begin
                d.missed = q.missed + MISS_W'(1);
                d.st     = S_RD_STAT;
            end
            default:   d.st = S_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_STOP;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.st)
            S_STOP:                     proc_state = PS_STOP;
            S_READY, S_NOTOWN:          proc_state = PS_WAIT;
            S_RECV, S_WB:               proc_state = PS_WRITE;
            S_DROP:                     proc_state = PS_DROP;
            default:                    proc_state = PS_FETCH;
        endcase
    end

    assign mem_req    = q.mreq;
    assign mem_we     = q.mwe;
    assign mem_addr   = q.maddr;
    assign mem_wdata  = q.mwdata;
    assign mem_be     = q.mbe;
    assign missed_cnt = q.missed;

    p_quiet_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_state == PS_STOP && $past(proc_state) == PS_STOP) |-> !mem_req);

    p_status_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && q.mstat) |->
            (!mem_wdata[OWN_BIT] && mem_wdata[LAST_BIT] && mem_be == 4'hF));

    p_within_buffer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !q.mstat) |->
            ((mem_addr - q.buf_addr) < AW'(q.size)) && (mem_be != 4'h0));

    p_miss_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (missed_cnt != $past(missed_cnt)) |-> (missed_cnt == $past(missed_cnt) + MISS_W'(1)));

    p_drop_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_state == PS_DROP && $past(proc_state) == PS_DROP) |-> !mem_req);
endmodule

// File: tb/tb_rx_ring_writer.sv
`timescale 1ns/1ps
module tb_rx_ring_writer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_in = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_err = 1'b0;
    logic        in_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [15:0] missed_cnt;
    logic [2:0]  proc_state;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] mem [0:1023];

    always #2.5 clk = ~clk;

    rx_ring_writer dut (
        .clk(clk), .rst_n(rst_n), .run(run), .base_wr(base_wr), .base_in(base_in),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
        .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .missed_cnt(missed_cnt), .proc_state(proc_state)
    );

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr[11:2]];
            end
        end
    end

    function automatic logic [7:0] rd_byte(input logic [31:0] a);
        return mem[a[11:2]][8*a[1:0] +: 8];
    endfunction

    function automatic logic [31:0] exp_stat(input int len, input logic err);
        logic [14:0] l = len[14:0];
        return {1'b0, l, err, 6'b0, 1'b1, 8'h00};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_desc(input logic [31:0] a, input logic own, input logic [31:0] ctl,
                            input logic [31:0] bufa);
        mem[a[11:2]]     = {own, 31'd0};
        mem[a[11:2] + 1] = ctl;
        mem[a[11:2] + 2] = bufa;
        mem[a[11:2] + 3] = 32'd0;
    endtask

    task automatic send_frame(input int len, input logic [7:0] seed, input logic err);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = seed + 8'(i);
            in_last  = (i == len - 1);
            in_err   = err && (i == len - 1);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic pulse_base(input logic [31:0] v);
        @(negedge clk);
        base_wr = 1'b1; base_in = v;
        @(negedge clk);
        base_wr = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 proc_state", 32'(proc_state), 32'd0);
        chk("R1 in_ready", 32'(in_ready), 32'd0);
        chk("R1 missed", 32'(missed_cnt), 32'd0);
        chk("R1 mem_req", 32'(mem_req), 32'd0);
    endtask

    task automatic t_start;
        pulse_base(32'h100);
        run = 1'b1;
        repeat (12) @(negedge clk);
        chk("R10 waiting code", 32'(proc_state), 32'd2);
    endtask

    task automatic t_basic;
        send_frame(20, 8'h10, 1'b0);
        chk("R5 status d0", mem[32'h100 >> 2], exp_stat(20, 1'b0));
        chk("R3 byte0", 32'(rd_byte(32'h400)), 32'h10);
        chk("R3 byte19", 32'(rd_byte(32'h413)), 32'h23);
        chk("R3 byte20 untouched", 32'(rd_byte(32'h414)), 32'hEE);
    endtask

    task automatic t_err_partial;
        send_frame(7, 8'h40, 1'b1);
        chk("R2 R5 status d1 err", mem[32'h110 >> 2], exp_stat(7, 1'b1));
        chk("R3 byte6", 32'(rd_byte(32'h486)), 32'h46);
        chk("R3 byte7 untouched", 32'(rd_byte(32'h487)), 32'hEE);
    endtask

    task automatic t_overflow;
        send_frame(30, 8'h80, 1'b0);
        chk("R4 length counts all", mem[32'h120 >> 2], exp_stat(30, 1'b0));
        chk("R4 last in-size byte", 32'(rd_byte(32'h509)), 32'h89);
        chk("R4 byte10 untouched", 32'(rd_byte(32'h50A)), 32'hEE);
        chk("R4 byte12 untouched", 32'(rd_byte(32'h50C)), 32'hEE);
    endtask

    task automatic t_wrap_drop;
        send_frame(4, 8'hC0, 1'b0);
        chk("R6 status d3", mem[32'h130 >> 2], exp_stat(4, 1'b0));
        chk("R7 parked waiting", 32'(proc_state), 32'd2);
        send_frame(5, 8'h60, 1'b0);
        chk("R7 missed count", 32'(missed_cnt), 32'd1);
        chk("R7 dropped frame no write", mem[32'h100 >> 2], exp_stat(20, 1'b0));
        chk("R7 dropped buffer untouched", 32'(rd_byte(32'h400)), 32'h10);
        mem[32'h100 >> 2] = 32'h8000_0000;
        send_frame(9, 8'h20, 1'b0);
        chk("R6 R7 wrapped into d0", mem[32'h100 >> 2], exp_stat(9, 1'b0));
        chk("R6 d0 buffer byte0", 32'(rd_byte(32'h400)), 32'h20);
        chk("R7 missed unchanged", 32'(missed_cnt), 32'd1);
    endtask

    task automatic t_base_ignored;
        mem[32'h110 >> 2] = 32'h8000_0000;
        pulse_base(32'h200);
        send_frame(3, 8'h70, 1'b0);
        chk("R9 running base write ignored", mem[32'h110 >> 2], exp_stat(3, 1'b0));
        chk("R9 no descriptor at new base", mem[32'h200 >> 2], 32'd0);
    endtask

    task automatic t_stop;
        bit seen_ready = 1'b0;
        @(negedge clk);
        run = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 R10 stopped code", 32'(proc_state), 32'd0);
        in_valid = 1'b1; in_data = 8'h55; in_last = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (in_ready) seen_ready = 1'b1;
        end
        in_valid = 1'b0; in_last = 1'b0;
        chk("R8 no ready while stopped", 32'(seen_ready), 32'd0);
        chk("R8 no miss while stopped", 32'(missed_cnt), 32'd1);
    endtask

    task automatic t_align;
        set_desc(32'h2C0, 1'b1, 32'h0200_0010, 32'h600);
        for (int a = 32'h600; a < 32'h640; a += 4) mem[a >> 2] = 32'hEEEE_EEEE;
        pulse_base(32'h2C8);
        @(negedge clk);
        run = 1'b1;
        repeat (12) @(negedge clk);
        send_frame(5, 8'h30, 1'b0);
        chk("R9 aligned base status", mem[32'h2C0 >> 2], exp_stat(5, 1'b0));
        chk("R9 aligned base byte4", 32'(rd_byte(32'h604)), 32'h34);
        chk("R9 unaligned address unused", mem[32'h2C8 >> 2], 32'h600);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
        for (int a = 32'h400; a < 32'h600; a += 4) mem[a >> 2] = 32'hEEEE_EEEE;
        set_desc(32'h100, 1'b1, 32'd64, 32'h400);
        set_desc(32'h110, 1'b1, 32'd64, 32'h480);
        set_desc(32'h120, 1'b1, 32'd10, 32'h500);
        set_desc(32'h130, 1'b1, 32'h0200_0040, 32'h580);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_start();
        t_basic();
        t_err_partial();
        t_overflow();
        t_wrap_drop();
        t_base_ignored();
        t_stop();
        t_align();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule